// File: doc/BRIEF.md
# Clocked Synchronous Serial Byte Port

This block is a byte-wide synchronous serial port that sits on a simple processor I/O bus. It has two registers. The control/status register holds the enables, the interrupt enable, the end flag and a 3-bit speed field. The data register is shared by both directions: software writes it before a transmit and reads it after a receive. Writing 1 to the transmit-enable or receive-enable bit starts exactly one 8-bit transfer. When the eighth bit has been shifted, that enable bit clears itself, the end flag is set, and an interrupt request is raised if the end interrupt is enabled.

The shift clock has two possible sources. It can be an internal clock, made by dividing the system clock by `BASE_DIV << speed`. In that case it is driven out on the clock pin, and only while a transfer is enabled. Otherwise it is an external clock taken from the same pin, which then acts as an input. The external clock is synchronised to the system clock with two flops before its edges are detected. Data moves least-significant bit first. Transmit data changes on the falling shift-clock edge, and receive data is sampled on the rising edge. An I/O-stop input aborts any transfer in progress.

Top module: `csio_port`

## Requirements
- R1: After reset the control register reads 0x07 and the outputs are ckOe=0, ckOut=1, txd=1 and irq=0. The control register layout is: bit 7 end flag (read-only), bit 6 end-interrupt enable, bit 5 receive enable, bit 4 transmit enable, bit 3 reads 0, bits 2:0 speed.
- R2: For speed values 0 to 6 the internal shift clock has a period of `BASE_DIV << speed` system clocks. During a transfer it starts high and falls first after half a period.
- R3: ckOe is 1 exactly when speed is not 7. The clock pin idles high and toggles only while a transfer is enabled.
- R4: Writing the control register with bit 4 set (and bit 5 clear) starts a transmit of the data register. txd presents bit 0 first, changes on each falling shift-clock edge, and returns high when the transfer ends.
- R5: With bit 5 set (and bit 4 clear), rxd is sampled on each rising shift-clock edge, least-significant bit first. The assembled byte is written into the data register when the transfer ends.
- R6: On the system clock edge that carries the 8th rising shift-clock edge, the active enable clears and the end flag is set.
- R7: irq equals end flag AND end-interrupt enable.
- R8: Any read or write of the data register clears the end flag.
- R9: A control write with both bits 4 and 5 set leaves both enables at 0. The two enables are never 1 together.
- R10: While ioStop is 1, both enables are held at 0, the clock pin returns high and txd returns high. The end flag is not set by an aborted transfer.
- R11: With speed 7, each edge of ckIn takes effect on txd or on the receive shift no later than the third system clock edge after it. The bits go out and come in as in R4 and R5.
- R12: The control register is at address CTRL_ADDR (default 0x0A) and the data register at DATA_ADDR (default 0x0B). busRdata shows the addressed register combinationally, and 0 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioStop | input | 1 | Aborts and holds off transfers |
| busAddr | input | ADDR_W | Register address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe (clears end flag on data reads) |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data of the addressed register |
| ckIn | input | 1 | External shift clock from the clock pin |
| ckOut | output | 1 | Internal shift clock to the clock pin |
| ckOe | output | 1 | Clock pin output enable |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |
| irq | output | 1 | End-of-transfer interrupt request |

## Verification
The bench builds the port with BASE_DIV=4, so the internal half period is 2 << speed system clocks. With that setting a full transfer at each of the seven internal rates fits in a few thousand cycles. Every rate, from the fastest to the slowest, is checked every cycle against a behavioural model of clock level, txd, enables, flag and irq. The address parameters keep their defaults. The external-clock cases use a ckIn slow enough that the synchroniser latency can be checked with a fixed margin.

// File: rtl/csio_pkg.sv
package csio_pkg;
  localparam int BUS_W = 8;

  typedef struct packed {
    logic loadTx;   // copy data register into shifter
    logic txBit;    // present next transmit bit
    logic rxBit;    // sample rxd into shifter
    logic rxDone;   // last receive sample, commit byte
    logic txEnd;    // return txd to idle level
  } csioStrobe_t;
endpackage

// File: rtl/csio_ctrl.sv
module csio_ctrl
  import csio_pkg::*;
#(
  parameter int BASE_DIV = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ioStop,
  input  logic             ctrlWr,
  input  logic             dataAcc,
  input  logic [BUS_W-1:0] wdata,
  input  logic             ckIn,
  output logic [BUS_W-1:0] ctrlRd,
  output csioStrobe_t      strb,
  output logic             ckOut,
  output logic             ckOe,
  output logic             irq
);
  localparam int HALF_BASE = BASE_DIV / 2;
  localparam int HALF_MAX  = HALF_BASE << 6;
  localparam int DIV_W     = $clog2(HALF_MAX + 1);
  localparam int CNT_W     = $clog2(BUS_W);
  localparam logic [2:0] SS_EXT = 3'b111;

  logic             teQ, reQ, eieQ, endFlagQ, sclkQ;
  logic [2:0]       ssQ;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic [2:0]       ckSync;
  logic active, intMode, wantTe, wantRe, startTx, startRx, tick;
  logic extFall, extRise, fallStb, riseStb, lastRise;

  function automatic logic [DIV_W-1:0] halfOf(input logic [2:0] s);
    return DIV_W'(HALF_BASE) << s;
  endfunction

  assign active   = teQ | reQ;
  assign intMode  = (ssQ != SS_EXT);
  assign wantTe   = wdata[4] & ~wdata[5];
  assign wantRe   = wdata[5] & ~wdata[4];
  assign startTx  = ctrlWr & ~ioStop & wantTe & ~teQ;
  assign startRx  = ctrlWr & ~ioStop & wantRe & ~reQ;
  assign tick     = intMode && (divCnt == '0);
  assign extFall  = ckSync[2] & ~ckSync[1];
  assign extRise  = ~ckSync[2] & ckSync[1];
  assign fallStb  = active & ~ioStop & (intMode ? (tick & sclkQ) : extFall);
  assign riseStb  = active & ~ioStop & (intMode ? (tick & ~sclkQ) : extRise);
  assign lastRise = riseStb && (bitCnt == CNT_W'(BUS_W - 1));

  always_ff @(posedge clk) begin
    if (!rstN) ckSync <= 3'b111;
    else       ckSync <= {ckSync[1:0], ckIn};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      teQ      <= 1'b0;
      reQ      <= 1'b0;
      eieQ     <= 1'b0;
      endFlagQ <= 1'b0;
      ssQ      <= SS_EXT;
      sclkQ    <= 1'b1;
      divCnt   <= '0;
      bitCnt   <= '0;
    end else begin
      if (ctrlWr) begin
        ssQ  <= wdata[2:0];
        eieQ <= wdata[6];
      end
      if (ioStop) begin
        teQ <= 1'b0;
        reQ <= 1'b0;
      end else if (ctrlWr) begin
        teQ <= wantTe;
        reQ <= wantRe;
      end else if (lastRise) begin
        teQ <= 1'b0;
        reQ <= 1'b0;
      end
      if (lastRise)     endFlagQ <= 1'b1;
      else if (dataAcc) endFlagQ <= 1'b0;
      if (startTx || startRx) begin
        divCnt <= halfOf(wdata[2:0]) - 1'b1;
        sclkQ  <= 1'b1;
        bitCnt <= '0;
      end else if (ioStop || !active) begin
        sclkQ <= 1'b1;
      end else begin
        if (riseStb) bitCnt <= bitCnt + 1'b1;
        if (intMode) begin
          if (tick) begin
            divCnt <= halfOf(ssQ) - 1'b1;
            sclkQ  <= ~sclkQ;
          end else begin
            divCnt <= divCnt - 1'b1;
          end
        end
      end
    end
  end

  assign ctrlRd      = {endFlagQ, eieQ, reQ, teQ, 1'b0, ssQ};
  assign ckOut       = intMode ? sclkQ : 1'b1;
  assign ckOe        = intMode;
  assign irq         = endFlagQ & eieQ;
  assign strb.loadTx = startTx;
  assign strb.txBit  = fallStb & teQ;
  assign strb.rxBit  = riseStb & reQ;
  assign strb.rxDone = lastRise & reQ;
  assign strb.txEnd  = ioStop | (lastRise & teQ) | (ctrlWr & teQ & ~wantTe);

  // R9
  one_direction_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(teQ && reQ));
  // R10
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioStop |=> (!teQ && !reQ && sclkQ));
  // R6
  end_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastRise && !ctrlWr && !ioStop) |=> (endFlagQ && !teQ && !reQ));
  // R3
  idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> sclkQ);
endmodule

// File: rtl/csio_datapath.sv
module csio_datapath
  import csio_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  csioStrobe_t      strb,
  input  logic             dataWr,
  input  logic [BUS_W-1:0] wdata,
  input  logic             rxd,
  output logic [BUS_W-1:0] dataRd,
  output logic             txd
);
  logic [BUS_W-1:0] dataQ, shiftQ, rxNext;
  logic             txdQ;

  assign rxNext = {rxd, shiftQ[BUS_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ  <= '0;
      shiftQ <= '0;
      txdQ   <= 1'b1;
    end else begin
      if (strb.rxDone)  dataQ <= rxNext;
      else if (dataWr)  dataQ <= wdata;
      if (strb.loadTx)     shiftQ <= dataQ;
      else if (strb.txBit) shiftQ <= shiftQ >> 1;
      else if (strb.rxBit) shiftQ <= rxNext;
      if (strb.txEnd || strb.loadTx) txdQ <= 1'b1;
      else if (strb.txBit)           txdQ <= shiftQ[0];
    end
  end

  assign dataRd = dataQ;
  assign txd    = txdQ;

  // R9
  single_shift_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.txBit, strb.rxBit}));
  // R5
  rxdone_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxDone |-> strb.rxBit);
endmodule

// File: rtl/csio_port.sv
module csio_port
  import csio_pkg::*;
#(
  parameter int              BASE_DIV  = 20,
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0A,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h0B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioStop,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              ckIn,
  output logic              ckOut,
  output logic              ckOe,
  output logic              txd,
  input  logic              rxd,
  output logic              irq
);
  logic        selCtrl, selData, ctrlWr, dataWr, dataAcc;
  logic [7:0]  ctrlRd, dataRd;
  csioStrobe_t strb;

  assign selCtrl = (busAddr == CTRL_ADDR);
  assign selData = (busAddr == DATA_ADDR);
  assign ctrlWr  = busWr & selCtrl;
  assign dataWr  = busWr & selData;
  assign dataAcc = (busWr | busRd) & selData;

  csio_ctrl #(.BASE_DIV(BASE_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .ioStop(ioStop), .ctrlWr(ctrlWr),
    .dataAcc(dataAcc), .wdata(busWdata), .ckIn(ckIn), .ctrlRd(ctrlRd),
    .strb(strb), .ckOut(ckOut), .ckOe(ckOe), .irq(irq)
  );

  csio_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataWr(dataWr),
    .wdata(busWdata), .rxd(rxd), .dataRd(dataRd), .txd(txd)
  );

  always_comb begin
    if (selCtrl)      busRdata = ctrlRd;
    else if (selData) busRdata = dataRd;
    else              busRdata = '0;
  end
endmodule

// File: tb/csio_port_tb.sv
module csio_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 4;
  localparam logic [7:0] CTRL = 8'h0A;
  localparam logic [7:0] DATA = 8'h0B;

  logic clk = 1'b0, rstN = 1'b0, ioStop = 1'b0;
  logic [7:0] busAddr = CTRL, busWdata = 8'h00, busRdata;
  logic busWr = 1'b0, busRd = 1'b0;
  logic ckIn = 1'b1, rxd = 1'b0;
  logic ckOut, ckOe, txd, irq;
  int checks = 0, fails = 0;

  csio_port #(.BASE_DIV(BASE)) u_dut (
    .clk(clk), .rstN(rstN), .ioStop(ioStop), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata),
    .ckIn(ckIn), .ckOut(ckOut), .ckOe(ckOe), .txd(txd), .rxd(rxd), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); @(negedge clk);
    busWr = 1'b0; busAddr = CTRL;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1; #1;
    d = busRdata;
    @(posedge clk); @(negedge clk);
    busRd = 1'b0; busAddr = CTRL;
  endtask

  // Behavioural model of one internally clocked transfer, compared each cycle.
  task automatic runInt(input bit isRx, input int ss, input logic [7:0] pat,
                        input bit eie, input bit clearByWrite);
    int half, k, nEnd;
    bit running;
    logic [7:0] rd;
    half = (BASE / 2) << ss;
    nEnd = 16 * half;
    if (!isRx) busWrite(DATA, pat);
    busWrite(CTRL, {1'b0, eie, isRx, ~isRx, 1'b0, 3'(ss)});
    for (int n = 0; n <= nEnd + 2; n++) begin
      k = (n / half > 16) ? 16 : n / half;
      running = (n < nEnd);
      #1;
      chk("R2 ckOut", int'(ckOut), running ? int'(k % 2 == 0) : 1);
      chk("R3 ckOe", int'(ckOe), 1);
      chk("R4 txd", int'(txd),
          (isRx || !running || k == 0) ? 1 : int'(pat[(k-1)/2]));
      chk("R6 ctrl", int'(busRdata),
          int'({~running, eie, running & isRx, running & ~isRx, 1'b0, 3'(ss)}));
      chk("R7 irq", int'(irq), int'(~running & eie));
      if (isRx) rxd = (k == 0 || k >= 16) ? 1'b0 : pat[(k-1)/2];
      @(negedge clk);
    end
    if (clearByWrite) begin
      busWrite(DATA, 8'h00);
      #1; chk("R8 flag cleared by write", int'(busRdata[7]), 0);
    end else begin
      busRead(DATA, rd);
      chk(isRx ? "R5 received byte" : "R12 data kept after transmit", int'(rd), int'(pat));
      #1; chk("R8 flag cleared by read", int'(busRdata[7]), 0);
    end
  endtask

  initial begin
    logic [7:0] rd;
    logic [7:0] pat;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 ctrl reset", int'(busRdata), 8'h07);
    chk("R1 ckOe", int'(ckOe), 0);
    chk("R1 ckOut", int'(ckOut), 1);
    chk("R1 txd", int'(txd), 1);
    chk("R1 irq", int'(irq), 0);
    @(negedge clk);
    busRead(DATA, rd);   chk("R12 data reset", int'(rd), 0);
    busRead(8'h33, rd);  chk("R12 unmapped", int'(rd), 0);
    busWrite(DATA, 8'hA5);
    busRead(DATA, rd);   chk("R12 data rw", int'(rd), 8'hA5);

    // R9 both enables requested
    busWrite(CTRL, 8'h30);
    #1;
    chk("R9 both blocked", int'(busRdata), 8'h00);
    chk("R3 ckOe internal", int'(ckOe), 1);
    repeat (6) @(negedge clk);
    #1; chk("R3 clock idle", int'(ckOut), 1);
    @(negedge clk);

    // internal transmits at every rate
    for (int s = 0; s < 7; s++) runInt(1'b0, s, 8'(8'hA5 ^ (s * 37)), 1'(s % 2 == 0), 1'b0);
    runInt(1'b0, 0, 8'h81, 1'b1, 1'b1);
    // internal receives
    runInt(1'b1, 0, 8'h3C, 1'b0, 1'b0);
    runInt(1'b1, 2, 8'hC1, 1'b1, 1'b0);

    // R10 abort by ioStop
    busWrite(DATA, 8'h00);
    busWrite(CTRL, 8'h51);
    repeat (10) @(negedge clk);
    ioStop = 1'b1;
    @(negedge clk);
    ioStop = 1'b0;
    #1;
    chk("R10 ctrl after stop", int'(busRdata), 8'h41);
    chk("R10 ckOut", int'(ckOut), 1);
    chk("R10 txd", int'(txd), 1);
    repeat (80) @(negedge clk);
    #1;
    chk("R10 no end flag", int'(busRdata), 8'h41);
    chk("R10 no irq", int'(irq), 0);
    @(negedge clk);

    // R11 external clock transmit
    pat = 8'h96;
    busWrite(DATA, pat);
    busWrite(CTRL, 8'h57);
    #1; chk("R3 ckOe external", int'(ckOe), 0);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk); ckIn = 1'b0;
      repeat (5) @(negedge clk);
      #1;
      chk("R11 ext txd", int'(txd), int'(pat[j]));
      chk("R11 ext busy", int'(busRdata[4]), 1);
      ckIn = 1'b1;
      repeat (5) @(negedge clk);
    end
    #1;
    chk("R6 ext end", int'(busRdata), 8'hC7);
    chk("R7 ext irq", int'(irq), 1);
    chk("R4 txd idle", int'(txd), 1);
    @(negedge clk);
    busRead(DATA, rd);

    // R11 external clock receive
    pat = 8'h5A;
    busWrite(CTRL, 8'h27);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk); ckIn = 1'b0;
      repeat (5) @(negedge clk);
      rxd = pat[j];
      ckIn = 1'b1;
      repeat (5) @(negedge clk);
    end
    #1;
    chk("R6 ext rx end", int'(busRdata), 8'h87);
    chk("R7 no irq when disabled", int'(irq), 0);
    @(negedge clk);
    busRead(DATA, rd);
    chk("R11 ext received byte", int'(rd), int'(pat));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule